// File: doc/BRIEF.md
# Distributed Shared-Bus Arbiter Node

This block decides who owns a shared external bus that is contended by up to six processor nodes and one host. It is meant to be instantiated once inside every node. Each copy watches the same request wires, the same lock wire and the same host request. Each copy also holds the same priority-mode setting. Because every copy applies the same rules to the same inputs from the same reset, all copies reach the same ownership decision on the same clock edge. No central arbiter is needed.

Each copy tells its own node whether it is the bus master. It also reports which node currently holds the bus and whether the host holds it. Priority among nodes is either fixed or rotating:

- Under fixed priority, the lowest node number wins, and a waiting lower-numbered node preempts the current owner.
- Under rotating priority, the search starts just after the node that most recently gave the bus up, and the owner is never preempted by another node.

Ownership changes pass through exactly one dead cycle. A lock wire pins the current owner so that an indivisible read-modify-write sequence cannot be split. The host, through its request/grant pair, outranks every node once the bus is free and unlocked.

Top module: `arb_node`

## Requirements
- R1: After reset, master_valid, own_master and host_grant are all 0, and the rotation pointer refers to the highest node (node NUM_NODES-1), so the first rotating search starts at node 0.
- R2: With the bus free, no host request, and rot_mode=0, the lowest-numbered requesting node owns the bus one cycle after the request is sampled.
- R3: With the bus free, no host request, and rot_mode=1, the winner is the first requesting node found by counting upward (with wrap) from the node after the one that last released the bus.
- R4: When ownership passes from one node to another node or to the host, exactly one cycle with neither a node master nor a host grant lies between the two owners.
- R5: An unlocked owner keeps the bus while it still requests it and there is no host request. Under rot_mode=1, a request from any other node never displaces it.
- R6: Under rot_mode=0, an unlocked owner releases the bus when any lower-numbered node requests.
- R7: While bus_lock=1 and a node owns the bus, that node keeps the bus regardless of its own request, other requests or host_req.
- R8: With the bus free, host_req=1 wins over all node requests and sets host_grant on the next cycle. host_grant stays high while host_req stays high, and the bus returns to free one cycle after host_req falls.
- R9: host_req=1 while a node owns the bus unlocked makes that node release the bus. The release counts as that node's release for rotation.
- R10: own_master is 1 exactly when master_valid=1 and master_id equals this copy's NODE_ID.
- R11: master_valid and host_grant are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all copies |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | NUM_NODES | Request line of each node, bit i = node i |
| bus_lock | input | 1 | Lock asserted by the current owner during an indivisible sequence |
| rot_mode | input | 1 | 0 = fixed priority, 1 = rotating priority |
| host_req | input | 1 | Host bus request |
| own_master | output | 1 | This node owns the bus |
| master_valid | output | 1 | Some node owns the bus |
| master_id | output | ARB_ID_W | Number of the owning node, 0 when no node owns |
| host_grant | output | 1 | Host owns the bus |

## Verification
The bench first targets the cases where rotating and fixed priority give different winners. A pointer that is not updated, or that is updated at the wrong moment, hands the bus to the lowest node instead of the next node in rotation. Fixed-priority preemption and rotating non-preemption are driven against each other. A design that mixes them up either keeps a high-numbered owner that should yield or ejects one that should stay. Lock is held across a dropped own request and a pending host request, where a broken hold releases mid-sequence. Every handover is checked for the single dead cycle, so a design that skips it shows two owners back to back.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int ARB_ID_W = 3;

    typedef enum logic [1:0] {
        BUS_FREE = 2'd0,
        BUS_NODE = 2'd1,
        BUS_HOST = 2'd2
    } bus_state_e;

    typedef struct packed {
        bus_state_e            st;
        logic [ARB_ID_W-1:0]   owner;
        logic [ARB_ID_W-1:0]   last;
    } arb_ctx_t;

    function automatic logic [ARB_ID_W-1:0] id_of(input int n);
        return ARB_ID_W'(n);
    endfunction

endpackage

// File: rtl/arb_pick.sv
module arb_pick
    import arb_pkg::*;
#(
    parameter int NUM_NODES = 6
) (
    input  logic [NUM_NODES-1:0] req,
    input  logic                 rotate,
    input  logic [ARB_ID_W-1:0]  last,
    output logic                 any,
    output logic [ARB_ID_W-1:0]  win
);
    localparam int TOP = NUM_NODES - 1;

    always_comb begin
        int start;
        int idx;
        logic found;
        found = 1'b0;
        win   = '0;
        start = rotate ? int'(last) : TOP;
        for (int k = 1; k <= NUM_NODES; k++) begin
            idx = (start + k) % NUM_NODES;
            if (!found && req[idx]) begin
                found = 1'b1;
                win   = id_of(idx);
            end
        end
        any = found;
    end
endmodule

// File: rtl/arb_hold.sv
module arb_hold
    import arb_pkg::*;
#(
    parameter int NUM_NODES = 6
) (
    input  logic [NUM_NODES-1:0] req,
    input  logic [ARB_ID_W-1:0]  owner,
    input  logic                 lock,
    input  logic                 rotate,
    input  logic                 host_req,
    output logic                 keep
);
    logic [NUM_NODES-1:0] below;
    logic [NUM_NODES-1:0] self_hit;

    for (genvar i = 0; i < NUM_NODES; i++) begin : g_mask
        assign below[i]    = req[i] && (id_of(i) < owner);
        assign self_hit[i] = req[i] && (id_of(i) == owner);
    end

    logic still_wants;
    logic preempted;

    assign still_wants = |self_hit;
    assign preempted   = !rotate && (|below);
    assign keep        = lock || (still_wants && !host_req && !preempted);
endmodule

// File: rtl/arb_node.sv
module arb_node
    import arb_pkg::*;
#(
    parameter int NUM_NODES = 6,
    parameter int NODE_ID   = 0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_NODES-1:0] bus_req,
    input  logic                 bus_lock,
    input  logic                 rot_mode,
    input  logic                 host_req,
    output logic                 own_master,
    output logic                 master_valid,
    output logic [ARB_ID_W-1:0]  master_id,
    output logic                 host_grant
);
    localparam logic [ARB_ID_W-1:0] LAST_RST = ARB_ID_W'(NUM_NODES - 1);
    localparam logic [ARB_ID_W-1:0] SELF     = ARB_ID_W'(NODE_ID);

    arb_ctx_t cur, nxt;
    logic any_req;
    logic [ARB_ID_W-1:0] winner;
    logic keep_bus;

    arb_pick #(.NUM_NODES(NUM_NODES)) u_pick (
        .req    (bus_req),
        .rotate (rot_mode),
        .last   (cur.last),
        .any    (any_req),
        .win    (winner)
    );

    arb_hold #(.NUM_NODES(NUM_NODES)) u_hold (
        .req      (bus_req),
        .owner    (cur.owner),
        .lock     (bus_lock),
        .rotate   (rot_mode),
        .host_req (host_req),
        .keep     (keep_bus)
    );

    always_comb begin
        nxt = cur;
        unique case (cur.st)
            BUS_FREE: begin
                if (host_req) begin
                    nxt.st = BUS_HOST;
                end else if (any_req) begin
                    nxt.st    = BUS_NODE;
                    nxt.owner = winner;
                end
            end
            BUS_NODE: begin
                if (!keep_bus) begin
                    nxt.st   = BUS_FREE;
                    nxt.last = cur.owner;
                end
            end
            BUS_HOST: begin
                if (!host_req) nxt.st = BUS_FREE;
            end
            default: nxt.st = BUS_FREE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur.st    <= BUS_FREE;
            cur.owner <= '0;
            cur.last  <= LAST_RST;
        end else begin
            cur <= nxt;
        end
    end

    assign master_valid = (cur.st == BUS_NODE);
    assign master_id    = master_valid ? cur.owner : '0;
    assign own_master   = master_valid && (cur.owner == SELF);
    assign host_grant   = (cur.st == BUS_HOST);
endmodule

// File: rtl/arb_node_chk.sv
module arb_node_chk
    import arb_pkg::*;
#(
    parameter int NUM_NODES = 6,
    parameter int NODE_ID   = 0
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_NODES-1:0] bus_req,
    input logic                 bus_lock,
    input logic                 rot_mode,
    input logic                 host_req,
    input logic                 own_master,
    input logic                 master_valid,
    input logic [ARB_ID_W-1:0]  master_id,
    input logic                 host_grant
);
    logic holder_req;
    always_comb begin
        holder_req = 1'b0;
        for (int i = 0; i < NUM_NODES; i++)
            if (id_of(i) == master_id && bus_req[i]) holder_req = 1'b1;
    end

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(master_valid && host_grant));

    a_r4_no_direct_swap: assert property (@(posedge clk) disable iff (rst)
        master_valid && $past(master_valid) |-> master_id == $past(master_id));

    a_r4_host_gap: assert property (@(posedge clk) disable iff (rst)
        $rose(host_grant) |-> !$past(master_valid));

    a_r7_lock_holds: assert property (@(posedge clk) disable iff (rst)
        master_valid && bus_lock |=> master_valid && $stable(master_id));

    a_r5_rotating_keep: assert property (@(posedge clk) disable iff (rst)
        master_valid && rot_mode && holder_req && !host_req |=> master_valid && $stable(master_id));

    a_r9_host_evicts: assert property (@(posedge clk) disable iff (rst)
        master_valid && host_req && !bus_lock |=> !master_valid);

    a_r8_host_stays: assert property (@(posedge clk) disable iff (rst)
        host_grant && host_req |=> host_grant);

    a_r8_host_needs_req: assert property (@(posedge clk) disable iff (rst)
        $rose(host_grant) |-> $past(host_req));

    a_r10_own_follows_req: assert property (@(posedge clk) disable iff (rst)
        $rose(own_master) |-> $past(bus_req[NODE_ID]));
endmodule

bind arb_node arb_node_chk #(.NUM_NODES(NUM_NODES), .NODE_ID(NODE_ID)) u_chk (.*);

// File: tb/arb_node_test.sv
module arb_node_test;
    localparam int N    = 6;
    localparam int ME   = 2;
    localparam int MAXC = 20000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [N-1:0] bus_req = '0;
    logic bus_lock = 1'b0;
    logic rot_mode = 1'b0;
    logic host_req = 1'b0;
    logic own_master, master_valid, host_grant;
    logic [2:0] master_id;

    always #4 clk = ~clk;

    arb_node #(.NUM_NODES(N), .NODE_ID(ME)) uut (
        .clk, .rst, .bus_req, .bus_lock, .rot_mode, .host_req,
        .own_master, .master_valid, .master_id, .host_grant
    );

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    // behavioural model: 0 free, 1 node, 2 host
    int m_st = 0, m_own = 0, m_last = N - 1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_st <= 0; m_own <= 0; m_last <= N - 1;
        end else begin
            case (m_st)
                0: begin
                    if (host_req) m_st <= 2;
                    else if (bus_req != 0) begin
                        int s; int hit;
                        s = rot_mode ? m_last : N - 1;
                        hit = -1;
                        for (int k = 1; k <= N; k++)
                            if (hit < 0 && bus_req[(s + k) % N]) hit = (s + k) % N;
                        m_st <= 1; m_own <= hit;
                    end
                end
                1: begin
                    bit stay; bit lower;
                    lower = 0;
                    for (int j = 0; j < m_own; j++) if (bus_req[j]) lower = 1;
                    stay = bus_lock || (bus_req[m_own] && !host_req && !(!rot_mode && lower));
                    if (!stay) begin m_st <= 0; m_last <= m_own; end
                end
                default: if (!host_req) m_st <= 0;
            endcase
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cmp_model();
        string t;
        t = (m_st == 2) ? "R8" : (bus_lock ? "R7" : "R4");
        chk({t, " master_valid"}, master_valid, m_st == 1);
        chk({t, " host_grant"}, host_grant, m_st == 2);
        chk({t, " master_id"}, master_id, (m_st == 1) ? m_own : 0);
        chk("R10 own_master", own_master, (m_st == 1) && (m_own == ME));
        chk("R11 exclusive", master_valid && host_grant, 0);
    endtask

    task automatic tick(input logic [N-1:0] r, input logic lk, input logic rm, input logic h);
        bus_req = r; bus_lock = lk; rot_mode = rm; host_req = h;
        @(negedge clk);
        cmp_model();
    endtask

    task automatic expect_node(input string tag, input int id);
        chk({tag, " valid"}, master_valid, 1);
        chk({tag, " id"}, master_id, id);
    endtask

    task automatic expect_free(input string tag);
        chk({tag, " valid"}, master_valid, 0);
        chk({tag, " host"}, host_grant, 0);
    endtask

    initial begin
        bit to;
        to = 0;
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                // R1: reset state
                expect_free("R1");
                chk("R1 own", own_master, 0);

                tick(6'b001100, 0, 0, 0); expect_node("R2", 2);
                chk("R10 own", own_master, 1);
                tick(6'b001100, 0, 0, 0); expect_node("R5", 2);
                tick(6'b001101, 0, 0, 0); expect_free("R6");
                tick(6'b001101, 0, 0, 0); expect_node("R4", 0);
                chk("R10 other", own_master, 0);
                tick(6'b001100, 0, 0, 0); expect_free("R4");
                tick(6'b000111, 0, 1, 0); expect_node("R3", 1);
                tick(6'b000111, 0, 1, 0); expect_node("R5", 1);
                tick(6'b000001, 1, 1, 1); expect_node("R7", 1);
                tick(6'b000001, 0, 1, 1); expect_free("R9");
                tick(6'b000001, 0, 1, 1); chk("R8 grant", host_grant, 1);
                chk("R11 master", master_valid, 0);
                tick(6'b000001, 0, 1, 1); chk("R8 hold", host_grant, 1);
                tick(6'b000101, 0, 1, 0); expect_free("R8");
                tick(6'b000101, 0, 1, 0); expect_node("R3", 2);
                chk("R10 own", own_master, 1);
                tick(6'b000001, 0, 1, 0); expect_free("R4");
                tick(6'b100001, 0, 1, 0); expect_node("R3", 5);

                for (int c = 0; c < 3000; c++) begin
                    logic [N-1:0] r;
                    r = N'($urandom);
                    tick(r, ($urandom % 5) == 0, c[9], ($urandom % 7) == 0);
                end
                rst = 1'b1;
                @(negedge clk);
                rst = 1'b0;
                expect_free("R1");
            end
            begin
                while (cycles < MAXC) @(posedge clk);
                to = 1;
            end
        join_any
        disable fork;
        if (to) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule